// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block turns single CPU-side memory requests into cycles on an 8-bit multiplexed parallel memory bus. The bus has one shared port that carries the low address byte and then the data byte, a separate port for the high address byte, an address latch enable, and active-low read and write strobes. An external transparent latch captures the low address byte while the latch enable is high. The latch enable falls before the data phase starts.

Every request is decoded as internal (0x0000 to 0x10FF) or external (0x1100 to 0xFFFF). External space is split into a lower and an upper sector at a boundary set by a 3-bit limit input. Each sector has its own 2-bit wait-state setting. Internal accesses still run the address phase and the latch-enable pulse on the bus, but they never assert a strobe. When the interface is disabled, every bus output enable is released. In that case an access above the internal range does not reach internal memory.

Top module: `xbus_ctrl`

## Requirements
- R1: An address at or below 0x10FF is internal. Such an access never drives `rd_n` or `wr_n` low, and an internal read returns `int_rdata` on `rdata`.
- R2: With the interface enabled, each access starts with exactly one cycle of `ale` high. In that cycle `ad_out` carries address bits 7:0 with `ad_oe` high, and `ah_out` carries address bits 15:8.
- R3: `ale` is low in every cycle in which a strobe is low.
- R4: Sector select works as follows. A `limit` of 0 places all external space in the upper sector. A `limit` of n from 1 to 7 sets the boundary at n×0x2000: addresses below it use `ws_lo` and addresses at or above it use `ws_hi`.
- R5: The external strobe stays low for 1, 2, 3 or 3 cycles for wait codes 0, 1, 2 and 3. With the interface enabled, `rdy` appears 2 cycles plus the strobe length after the first clock edge that sees `req`. An internal access behaves like wait code 0.
- R6: Wait code 3 adds one idle hold cycle after the strobe rises and before `rdy`. In that cycle both strobes and `ale` are inactive.
- R7: A write drives `wdata` on `ad_out` with `ad_oe` high while `wr_n` is low. A read keeps `ad_oe` low while `rd_n` is low and returns the value `ad_in` held in the last strobe cycle.
- R8: `rdy` is high for exactly one cycle. A `req` that is still high during that cycle is not accepted until the following cycle.
- R9: `ah_oe[i]` is high only when `en` is high and i < `hi_width`. `ah_oe` is zero when `hi_width` is 0.
- R10: When `en` is low, `ad_oe`, `ah_oe`, `ale` and `ctl_oe` stay low. Each access completes with `rdy` 2 cycles after acceptance. An external read returns 0x00 and an internal read returns `int_rdata`.
- R11: After reset, `rdy`, `ale` and `ad_oe` are low and both strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Interface enable |
| limit | input | 3 | Sector boundary select |
| ws_lo | input | 2 | Wait code for the lower sector |
| ws_hi | input | 2 | Wait code for the upper sector |
| hi_width | input | 4 | Number of high address pins driven |
| req | input | 1 | Access request (level) |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Access address |
| wdata | input | 8 | Write data |
| int_rdata | input | 8 | Read data from internal memory |
| rdy | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read data |
| ad_in | input | 8 | Shared port input value |
| ad_out | output | 8 | Shared port output value |
| ad_oe | output | 1 | Shared port output enable |
| ah_out | output | 8 | High address byte |
| ah_oe | output | 8 | Per-pin enable for the high address port |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ctl_oe | output | 1 | Enable for the ale and strobe pins |

## Verification
The bench builds the block with its default parameters: a 16-bit address, an 8-bit data path and a 3-bit limit field. These defaults make the 0x10FF/0x1100 internal edge reachable, and they make the sector edges at 0x2000, 0x4000 and 0xE000 reachable from both sides. The stimulus table runs all four wait codes, both sectors, limit 0, reads and writes, and disabled accesses through a bench latch and memory model. Directed tests then cover reset, the high-address pin mask and a request held high through the ready pulse.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int XB_AW  = 16;
    localparam int XB_DW  = 8;
    localparam int XB_HW  = XB_AW - XB_DW;
    localparam int XB_LW  = 3;
    localparam int XB_HCW = $clog2(XB_HW + 1);
    localparam logic [XB_AW-1:0] XB_INT_LAST = 16'h10FF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_STRB,
        ST_HOLD,
        ST_FIN
    } xb_state_e;

    typedef struct packed {
        logic             we;
        logic             ext;
        logic [XB_AW-1:0] addr;
        logic [XB_DW-1:0] wdata;
        logic [1:0]       ws;
    } xb_req_t;

    // Strobe cycles beyond the first one, per wait code
    function automatic logic [1:0] strobe_extra(input logic [1:0] ws);
        case (ws)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    function automatic logic hold_needed(input logic [1:0] ws);
        return ws == 2'd3;
    endfunction

endpackage

// File: rtl/xbus_decode.sv
module xbus_decode
    import xbus_pkg::*;
#(
    parameter int AW = XB_AW,
    parameter int LW = XB_LW,
    parameter logic [AW-1:0] INT_LAST = XB_INT_LAST
) (
    input  logic [AW-1:0] addr,
    input  logic [LW-1:0] limit,
    input  logic [1:0]    ws_lo,
    input  logic [1:0]    ws_hi,
    output logic          ext,
    output logic          upper,
    output logic [1:0]    ws
);
    localparam int SHIFT = AW - LW;

    logic [AW-1:0] boundary;

    always_comb begin
        boundary = {limit, {SHIFT{1'b0}}};
        ext      = addr > INT_LAST;
        upper    = (limit == '0) || (addr >= boundary);
        ws       = ext ? (upper ? ws_hi : ws_lo) : 2'd0;
    end

endmodule

// File: rtl/xbus_fsm.sv
module xbus_fsm
    import xbus_pkg::*;
#(
    parameter int DW = XB_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          req,
    input  logic          we,
    input  logic [XB_AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          dec_ext,
    input  logic [1:0]    dec_ws,
    input  logic [DW-1:0] ad_in,
    input  logic [DW-1:0] int_rdata,
    output xb_state_e     st,
    output xb_req_t       cur,
    output logic          rdy,
    output logic [DW-1:0] rdata
);
    logic [1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cur   <= '0;
            cnt   <= '0;
            rdy   <= 1'b0;
            rdata <= '0;
        end else begin
            rdy <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (req && !rdy) begin
                        cur.we    <= we;
                        cur.ext   <= dec_ext;
                        cur.addr  <= addr;
                        cur.wdata <= wdata;
                        cur.ws    <= dec_ws;
                        st        <= en ? ST_ADDR : ST_FIN;
                    end
                end
                ST_ADDR: begin
                    cnt <= strobe_extra(cur.ws);
                    st  <= ST_STRB;
                end
                ST_STRB: begin
                    if (cnt == 2'd0) begin
                        if (!cur.we)
                            rdata <= cur.ext ? ad_in : int_rdata;
                        if (cur.ext && hold_needed(cur.ws)) begin
                            st <= ST_HOLD;
                        end else begin
                            st  <= ST_IDLE;
                            rdy <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt - 2'd1;
                    end
                end
                ST_HOLD: begin
                    st  <= ST_IDLE;
                    rdy <= 1'b1;
                end
                ST_FIN: begin
                    if (!cur.we)
                        rdata <= cur.ext ? '0 : int_rdata;
                    st  <= ST_IDLE;
                    rdy <= 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_RDY_PULSE: assert property (@(posedge clk) disable iff (rst)
        rdy |=> !rdy); // R8

    AST_HOLD_FOLLOWS_STRB: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOLD) |-> ($past(st) == ST_STRB)); // R6

    AST_ACCEPT_AFTER_RDY: assert property (@(posedge clk) disable iff (rst)
        rdy |=> (st == ST_IDLE)); // R8

endmodule

// File: rtl/xbus_pads.sv
module xbus_pads
    import xbus_pkg::*;
#(
    parameter int DW  = XB_DW,
    parameter int HW  = XB_HW,
    parameter int HCW = XB_HCW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  xb_state_e      st,
    input  xb_req_t        cur,
    input  logic [HCW-1:0] hi_width,
    output logic [DW-1:0]  ad_out,
    output logic           ad_oe,
    output logic [HW-1:0]  ah_out,
    output logic [HW-1:0]  ah_oe,
    output logic           ale,
    output logic           rd_n,
    output logic           wr_n,
    output logic           ctl_oe
);
    logic in_strb;

    always_comb begin
        in_strb = en && (st == ST_STRB);
        ale     = en && (st == ST_ADDR);
        ad_out  = (st == ST_ADDR) ? cur.addr[DW-1:0] : cur.wdata;
        ad_oe   = ale || (in_strb && cur.we);
        ah_out  = cur.addr[XB_AW-1 -: HW];
        rd_n    = !(in_strb && cur.ext && !cur.we);
        wr_n    = !(in_strb && cur.ext &&  cur.we);
        ctl_oe  = en;
    end

    for (genvar i = 0; i < HW; i++) begin : g_hi_oe
        assign ah_oe[i] = en && (32'(hi_width) > i);
    end

    AST_STROBE_ALE_LOW: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> !ale); // R3

    AST_INT_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE && !cur.ext) |-> (rd_n && wr_n)); // R1

    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe); // R7

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        rd_n || wr_n); // R7

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en |-> (!ad_oe && !ale && ah_oe == '0 && rd_n && wr_n)); // R10

    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $rose(ale) |=> !ale); // R2

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOLD) |-> (cur.ws == 2'd3 && rd_n && wr_n && !ale)); // R6

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int AW  = XB_AW,
    parameter int DW  = XB_DW,
    parameter int LW  = XB_LW,
    parameter int HW  = AW - DW,
    parameter int HCW = $clog2(HW + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic [LW-1:0]  limit,
    input  logic [1:0]     ws_lo,
    input  logic [1:0]     ws_hi,
    input  logic [HCW-1:0] hi_width,
    input  logic           req,
    input  logic           we,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    input  logic [DW-1:0]  int_rdata,
    output logic           rdy,
    output logic [DW-1:0]  rdata,
    input  logic [DW-1:0]  ad_in,
    output logic [DW-1:0]  ad_out,
    output logic           ad_oe,
    output logic [HW-1:0]  ah_out,
    output logic [HW-1:0]  ah_oe,
    output logic           ale,
    output logic           rd_n,
    output logic           wr_n,
    output logic           ctl_oe
);
    logic       dec_ext;
    logic       dec_upper;
    logic [1:0] dec_ws;
    xb_state_e  st;
    xb_req_t    cur;

    xbus_decode #(.AW(AW), .LW(LW)) u_decode (
        .addr  (addr),
        .limit (limit),
        .ws_lo (ws_lo),
        .ws_hi (ws_hi),
        .ext   (dec_ext),
        .upper (dec_upper),
        .ws    (dec_ws)
    );

    xbus_fsm #(.DW(DW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .req       (req),
        .we        (we),
        .addr      (addr),
        .wdata     (wdata),
        .dec_ext   (dec_ext),
        .dec_ws    (dec_ws),
        .ad_in     (ad_in),
        .int_rdata (int_rdata),
        .st        (st),
        .cur       (cur),
        .rdy       (rdy),
        .rdata     (rdata)
    );

    xbus_pads #(.DW(DW), .HW(HW), .HCW(HCW)) u_pads (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .st       (st),
        .cur      (cur),
        .hi_width (hi_width),
        .ad_out   (ad_out),
        .ad_oe    (ad_oe),
        .ah_out   (ah_out),
        .ah_oe    (ah_oe),
        .ale      (ale),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .ctl_oe   (ctl_oe)
    );

    AST_SECTOR_WS: assert property (@(posedge clk) disable iff (rst)
        (dec_ext && dec_upper) |-> (dec_ws == ws_hi)); // R4

endmodule

// File: tb/tb_xbus_ctrl.sv
`timescale 1ns/1ps
module tb_xbus_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic       en;
    logic [2:0] limit;
    logic [1:0] ws_lo, ws_hi;
    logic [3:0] hi_width;
    logic       req, we;
    logic [15:0] addr;
    logic [7:0] wdata, int_rdata, ad_in;
    logic       rdy;
    logic [7:0] rdata, ad_out, ah_out, ah_oe;
    logic       ad_oe, ale, rd_n, wr_n, ctl_oe;

    always #2.5 clk = ~clk;

    xbus_ctrl dut (
        .clk(clk), .rst(rst), .en(en), .limit(limit), .ws_lo(ws_lo),
        .ws_hi(ws_hi), .hi_width(hi_width), .req(req), .we(we),
        .addr(addr), .wdata(wdata), .int_rdata(int_rdata), .rdy(rdy),
        .rdata(rdata), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .ah_out(ah_out), .ah_oe(ah_oe), .ale(ale), .rd_n(rd_n),
        .wr_n(wr_n), .ctl_oe(ctl_oe)
    );

    // External transparent latch and memory model
    logic [7:0] lat_lo = 8'h00;
    always_latch if (ale) lat_lo = ad_out;
    assign ad_in = rd_n ? 8'h00 : (lat_lo ^ ah_out ^ 8'h5A);

    int total = 0;
    int fails = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic        en;
        logic [2:0]  lim;
        logic [1:0]  wlo;
        logic [1:0]  whi;
        logic        we;
        logic [15:0] addr;
        logic [7:0]  wd;
        logic [3:0]  lat;
        logic [1:0]  strb;
        logic [7:0]  rd;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd0, 2'd0, 2'd2, 1'b0, 16'h2345, 8'h00, 4'd5, 2'd3, 8'h3C},
        '{1'b1, 3'd2, 2'd1, 2'd0, 1'b0, 16'h3000, 8'h00, 4'd4, 2'd2, 8'h6A},
        '{1'b1, 3'd2, 2'd1, 2'd0, 1'b0, 16'h4000, 8'h00, 4'd3, 2'd1, 8'h1A},
        '{1'b1, 3'd2, 2'd3, 2'd0, 1'b1, 16'h1100, 8'hA5, 4'd6, 2'd3, 8'h00},
        '{1'b1, 3'd0, 2'd3, 2'd3, 1'b0, 16'h10FF, 8'h00, 4'd3, 2'd0, 8'hC3},
        '{1'b1, 3'd0, 2'd3, 2'd3, 1'b1, 16'h0000, 8'h77, 4'd3, 2'd0, 8'h00},
        '{1'b1, 3'd7, 2'd0, 2'd1, 1'b0, 16'hDFFF, 8'h00, 4'd3, 2'd1, 8'h7A},
        '{1'b1, 3'd7, 2'd0, 2'd1, 1'b0, 16'hE000, 8'h00, 4'd4, 2'd2, 8'hBA},
        '{1'b1, 3'd1, 2'd2, 2'd3, 1'b1, 16'h1FFF, 8'h3C, 4'd5, 2'd3, 8'h00},
        '{1'b1, 3'd1, 2'd2, 2'd3, 1'b1, 16'hFFFF, 8'h81, 4'd6, 2'd3, 8'h00},
        '{1'b0, 3'd0, 2'd0, 2'd0, 1'b0, 16'h8000, 8'h00, 4'd2, 2'd0, 8'h00},
        '{1'b0, 3'd0, 2'd0, 2'd0, 1'b0, 16'h0100, 8'h00, 4'd2, 2'd0, 8'hC3}
    };

    task automatic run_vec(input vec_t v);
        int lat = 0, strb = 0, ale_n = 0, rel_bad = 0, dis_bad = 0;
        logic [7:0] a_lo = 8'h00, a_hi = 8'h00, wcap = 8'h00;
        en = v.en; limit = v.lim; ws_lo = v.wlo; ws_hi = v.whi;
        we = v.we; addr = v.addr; wdata = v.wd; req = 1'b1;
        while (lat < 20) begin
            @(negedge clk);
            lat++;
            if (ale) begin ale_n++; a_lo = ad_out; a_hi = ah_out; end
            if (ctl_oe && (!rd_n || !wr_n)) strb++;
            if (!wr_n && ad_oe) wcap = ad_out;
            if (!rd_n && ad_oe) rel_bad++;
            if (!v.en && (ad_oe || ale || ctl_oe || ah_oe != 8'h00)) dis_bad++;
            if (rdy) break;
        end
        req = 1'b0;
        chk("R5 R6 R8 latency to rdy", lat, v.lat);
        chk("R1 R4 R5 strobe cycles", strb, v.strb);
        if (v.en) begin
            chk("R2 ale pulse count", ale_n, 1);
            chk("R2 latched low address", a_lo, v.addr[7:0]);
            chk("R2 high address", a_hi, v.addr[15:8]);
            chk("R7 shared port released while reading", rel_bad, 0);
        end else begin
            chk("R10 outputs released when disabled", dis_bad, 0);
        end
        if (v.we && v.strb != 0) chk("R7 write data on port", wcap, v.wd);
        if (!v.we) chk("R1 R7 R10 read data", rdata, v.rd);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int n;
        rst = 1'b1; en = 1'b1; limit = 3'd0; ws_lo = 2'd0; ws_hi = 2'd0;
        hi_width = 4'd8; req = 1'b0; we = 1'b0; addr = 16'h0000;
        wdata = 8'h00; int_rdata = 8'hC3;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 rdy after reset", rdy, 0);
        chk("R11 ale after reset", ale, 0);
        chk("R11 ad_oe after reset", ad_oe, 0);
        chk("R11 strobes after reset", {rd_n, wr_n}, 2'b11);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i]);
            @(negedge clk);
        end

        // R9 high address pin mask
        en = 1'b1; hi_width = 4'd4; @(negedge clk);
        chk("R9 ah_oe width 4", ah_oe, 8'h0F);
        hi_width = 4'd0; @(negedge clk);
        chk("R9 ah_oe width 0", ah_oe, 8'h00);
        hi_width = 4'd8; en = 1'b0; @(negedge clk);
        chk("R9 R10 ah_oe disabled", ah_oe, 8'h00);
        chk("R10 ctl_oe disabled", ctl_oe, 0);
        en = 1'b1; @(negedge clk);
        chk("R9 ah_oe width 8", ah_oe, 8'hFF);

        // R8 request held high through rdy
        limit = 3'd0; ws_hi = 2'd0; we = 1'b0; addr = 16'h2000; req = 1'b1;
        n = 0;
        while (n < 20) begin @(negedge clk); n++; if (rdy) break; end
        chk("R8 first access latency", n, 3);
        @(negedge clk);
        chk("R8 rdy one cycle", rdy, 0);
        chk("R8 no accept during rdy cycle", ale, 0);
        @(negedge clk);
        chk("R8 next access accepted after rdy", ale, 1);
        req = 1'b0;
        n = 0;
        while (n < 20) begin @(negedge clk); n++; if (rdy) break; end
        chk("R8 second access completes", n, 2);
        chk("R7 second read data", rdata, 8'h00 ^ 8'h20 ^ 8'h5A);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule